// File: doc/BRIEF.md
# Transfer Controller Activation Router

This block sits between a set of peripheral interrupt flags and two consumers: the CPU interrupt path and a data transfer engine. A per-source routing bit decides where each flag goes. A flag whose routing bit is 0 shows up as a plain CPU interrupt request. A flag whose routing bit is 1 is instead offered to a fixed-priority arbiter. The arbiter hands one winner at a time to the transfer engine. Software can also request a transfer by writing a vector together with a software-request bit. That request ranks below every hardware source.

When the engine reports the end of the last link of a transfer, the block applies one of two completion paths. The engine's done report carries a disable-interrupt bit and a count-exhausted flag. If both are 0, the block pulses a clear back to the peripheral flag and keeps the routing bit, so later events keep going to the engine. If either is 1, the routing bit is dropped instead. The flag stays set and therefore reaches the CPU as an ordinary interrupt. Software requests follow the same split: either the software-request bit is cleared, or it is kept and a software-completion interrupt is raised toward the CPU.

Top module: `xfer_act_router`

## Requirements
- R1: After reset the block issues no start, no flag clear and no software interrupt. It has no transfer in progress. Both registers read back as 0.
- R2: `cpu_irq_o[i]` is high exactly while `irq_flag_i[i]` is 1 and routing bit i is 0. A flag whose routing bit is 0 never starts a transfer.
- R3: Among pending requests, the lowest hardware index wins. A hardware request is one where the flag is set and the routing bit is 1. The software request, reported as source code NUM_SRC (8), is granted only when no hardware request is pending.
- R4: `eng_start_o` is a one-cycle pulse. `eng_src_o` holds the granted source while the transfer is in progress. No new start is issued until a done with `eng_last_i`=1 is reported.
- R5: On a final done for hardware source s with `eng_dis_i`=0 and `eng_cnt_end_i`=0, `flag_clr_o` is exactly bit s for one cycle, in the cycle after done. Routing bit s stays 1.
- R6: On a final done for hardware source s with `eng_dis_i`=1 or `eng_cnt_end_i`=1, routing bit s reads 0 from the next cycle. No clear pulse is sent, so the still-set flag raises `cpu_irq_o[s]`.
- R7: Writing register address 1 with bit 7 set requests a software transfer. Bits 6:0 carry the vector. The resulting start shows source code 8, and `eng_vec_o` carries the written vector.
- R8: On a final done for the software source with `eng_dis_i`=0 and `eng_cnt_end_i`=0, the software-request bit (address 1, bit 7) is cleared and `cpu_swi_o` stays 0.
- R9: On a final done for the software source with `eng_dis_i`=1 or `eng_cnt_end_i`=1, the software-request bit stays 1 and `cpu_swi_o` rises. The block does not start the request again. Writing address 1 with bit 7 at 0 drops `cpu_swi_o`.
- R10: A done with `eng_last_i`=0 is a chain link. It produces no clear and no register change, and the transfer stays in progress.
- R11: When a register write and a completion clear hit the same routing bit in the same cycle, the clear wins.
- R12: Register address 0 holds the routing bits, bit i for source i. Address 1 holds the software-request bit at bit 7 and the vector at bits 6:0. Reads are combinational from `reg_addr_i`, and writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_flag_i | input | NUM_SRC | Peripheral interrupt flags (levels) |
| cpu_irq_o | output | NUM_SRC | Interrupt requests toward the CPU |
| flag_clr_o | output | NUM_SRC | One-cycle clear pulses to the peripherals |
| cpu_swi_o | output | 1 | Software-transfer completion interrupt |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select (0 routing, 1 software request) |
| reg_wdata_i | input | REG_W | Register write data |
| reg_rdata_o | output | REG_W | Register read data |
| eng_start_o | output | 1 | Start pulse to the transfer engine |
| eng_src_o | output | SEL_W | Granted source (NUM_SRC means software) |
| eng_vec_o | output | VEC_W | Vector of a software transfer |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_last_i | input | 1 | Completion belongs to the last link of a chain |
| eng_dis_i | input | 1 | Disable-interrupt bit of the finished transfer |
| eng_cnt_end_i | input | 1 | Transfer count exhausted |

## Verification
The checker watches every cycle for the following. Clear pulses must be one-hot and must trace back to a final done on the keep path. A chain-link done must produce no clear. Starts must be single pulses and never overlap a transfer in progress. Each start must go to the lowest-index pending hardware request, or to software only when no hardware request was pending. The bench scenarios are needed to show the register-level effects. These are: the routing bit dropping on the interrupt path, the software bit clearing or sticking, `cpu_swi_o` holding until software releases it, the absence of a restart, and a clear beating a same-cycle write.

// File: rtl/act_pkg.sv
// Shared definitions for the transfer activation router.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package act_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;

    // Register width able to hold the routing bits or {request, vector}.
    function automatic int reg_width(input int nsrc, input int vw);
        return (nsrc > vw + 1) ? nsrc : vw + 1;
    endfunction

endpackage

// File: rtl/act_regs.sv
// Routing-bit register and software-request register with completion clears.
// Assumes: clears from the sequencer arrive as single-cycle strobes and
// take priority over a same-cycle write; reads are combinational.
module act_regs #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 7,
    parameter int REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_SRC-1:0] en_clr,
    input  logic               sw_clr,
    input  logic               swi_set,
    output logic [NUM_SRC-1:0] en_q,
    output logic               sw_en_q,
    output logic [VEC_W-1:0]   sw_vec_q,
    output logic               swi_q,
    output logic [REG_W-1:0]   rdata
);

    logic wr_route;
    logic wr_sw;

    assign wr_route = we && !addr;
    assign wr_sw    = we && addr;

    // Routing bits: software write, then hardware clear on top of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (wr_route ? wdata[NUM_SRC-1:0] : en_q) & ~en_clr;
        end
    end

    // Software request bit and vector; completion clear wins over write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en_q  <= 1'b0;
            sw_vec_q <= '0;
        end else begin
            if (wr_sw) begin
                sw_en_q  <= wdata[VEC_W];
                sw_vec_q <= wdata[VEC_W-1:0];
            end
            if (sw_clr) begin
                sw_en_q <= 1'b0;
            end
        end
    end

    // Software completion interrupt: set by the sequencer, released by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swi_q <= 1'b0;
        end else if (swi_set) begin
            swi_q <= 1'b1;
        end else if (wr_sw && !wdata[VEC_W]) begin
            swi_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[NUM_SRC-1:0] = en_q;
        end else begin
            rdata[VEC_W:0] = {sw_en_q, sw_vec_q};
        end
    end

endmodule

// File: rtl/act_arbiter.sv
// Fixed-priority arbiter: lowest hardware index first, software last.
// Assumes: requests are levels sampled only while the sequencer is idle.
module act_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               sw_req,
    output logic               grant_vld,
    output logic [SEL_W-1:0]   grant_idx
);

    logic [NUM_SRC:0]   seen;
    logic [NUM_SRC-1:0] first;
    logic [SEL_W-1:0]   hw_idx;

    assign seen[0] = 1'b0;

    // Prefix chain: a request wins only if no lower index is requesting.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign first[i]  = hw_req[i] && !seen[i];
        assign seen[i+1] = seen[i] || hw_req[i];
    end

    // Encode the single winning hardware index.
    always_comb begin
        hw_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (first[i]) begin
                hw_idx = SEL_W'(i);
            end
        end
    end

    // Hardware beats software; software is reported as code NUM_SRC.
    assign grant_vld = seen[NUM_SRC] || sw_req;
    assign grant_idx = seen[NUM_SRC] ? hw_idx : SEL_W'(NUM_SRC);

endmodule

// File: rtl/act_seq.sv
// Start/complete sequencer toward the transfer engine.
// Assumes: the engine raises done (with last=1) once per started transfer,
// possibly after chain-link dones with last=0. One idle-settle cycle after
// completion lets peripherals drop a cleared flag before re-arbitration.
module act_seq
    import act_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 7,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_vld,
    input  logic [SEL_W-1:0]   grant_idx,
    input  logic [VEC_W-1:0]   sw_vec,
    input  logic               done,
    input  logic               last,
    input  logic               dis,
    input  logic               cnt_end,
    output logic               start,
    output logic [SEL_W-1:0]   cur_src,
    output logic [VEC_W-1:0]   cur_vec,
    output logic [NUM_SRC-1:0] flag_clr,
    output logic [NUM_SRC-1:0] en_clr,
    output logic               sw_clr,
    output logic               swi_set
);

    seq_state_e         state;
    logic [NUM_SRC-1:0] cur_oh;
    logic               finish;
    logic               keep;
    logic               is_sw;

    assign finish = (state == ST_BUSY) && done && last;
    assign keep   = !dis && !cnt_end;
    assign is_sw  = (cur_src == SEL_W'(NUM_SRC));

    // One-hot of the source under service.
    always_comb begin
        cur_oh = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cur_src == SEL_W'(i)) begin
                cur_oh[i] = 1'b1;
            end
        end
    end

    // Completion strobes to the register block (applied at this edge).
    assign en_clr  = (finish && !is_sw && !keep) ? cur_oh : '0;
    assign sw_clr  = finish && is_sw && keep;
    assign swi_set = finish && is_sw && !keep;

    // State machine, start pulse and captured grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            start   <= 1'b0;
            cur_src <= '0;
            cur_vec <= '0;
        end else begin
            start <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (grant_vld) begin
                        start   <= 1'b1;
                        cur_src <= grant_idx;
                        cur_vec <= sw_vec;
                        state   <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (finish) begin
                        state <= ST_SETTLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Registered single-cycle clear toward the peripheral flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_clr <= '0;
        end else begin
            flag_clr <= (finish && !is_sw && keep) ? cur_oh : '0;
        end
    end

endmodule

// File: rtl/xfer_act_router.sv
// Top: routes peripheral flags to the CPU or to the transfer engine,
// arbitrates activations and applies completion rules.
// Assumes: parameters SEL_W and REG_W keep their derived defaults.
module xfer_act_router #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 7,
    parameter int SEL_W   = $clog2(NUM_SRC + 1),
    parameter int REG_W   = act_pkg::reg_width(NUM_SRC, VEC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_flag_i,
    output logic [NUM_SRC-1:0] cpu_irq_o,
    output logic [NUM_SRC-1:0] flag_clr_o,
    output logic               cpu_swi_o,
    input  logic               reg_we_i,
    input  logic               reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               eng_start_o,
    output logic [SEL_W-1:0]   eng_src_o,
    output logic [VEC_W-1:0]   eng_vec_o,
    input  logic               eng_done_i,
    input  logic               eng_last_i,
    input  logic               eng_dis_i,
    input  logic               eng_cnt_end_i
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] en_clr;
    logic               sw_en_q;
    logic [VEC_W-1:0]   sw_vec_q;
    logic               swi_q;
    logic               sw_clr;
    logic               swi_set;
    logic               grant_vld;
    logic [SEL_W-1:0]   grant_idx;

    act_regs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
        .en_clr(en_clr), .sw_clr(sw_clr), .swi_set(swi_set),
        .en_q(en_q), .sw_en_q(sw_en_q), .sw_vec_q(sw_vec_q),
        .swi_q(swi_q), .rdata(reg_rdata_o)
    );

    act_arbiter #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_arb (
        .hw_req(irq_flag_i & en_q),
        .sw_req(sw_en_q && !swi_q),
        .grant_vld(grant_vld),
        .grant_idx(grant_idx)
    );

    act_seq #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .grant_vld(grant_vld), .grant_idx(grant_idx), .sw_vec(sw_vec_q),
        .done(eng_done_i), .last(eng_last_i), .dis(eng_dis_i),
        .cnt_end(eng_cnt_end_i),
        .start(eng_start_o), .cur_src(eng_src_o), .cur_vec(eng_vec_o),
        .flag_clr(flag_clr_o), .en_clr(en_clr), .sw_clr(sw_clr),
        .swi_set(swi_set)
    );

    // CPU sees a flag only while it is not routed to the engine.
    assign cpu_irq_o = irq_flag_i & ~en_q;
    assign cpu_swi_o = swi_q;

endmodule

// File: rtl/act_router_chk.sv
// Protocol and priority checker for xfer_act_router, attached by bind.
// Assumes: observes ports plus the routing and software-request state.
module act_router_chk #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_flag_i,
    input logic [NUM_SRC-1:0] en_q,
    input logic               sw_en_q,
    input logic               swi_q,
    input logic               eng_start_o,
    input logic [SEL_W-1:0]   eng_src_o,
    input logic               eng_done_i,
    input logic               eng_last_i,
    input logic               eng_dis_i,
    input logic               eng_cnt_end_i,
    input logic [NUM_SRC-1:0] flag_clr_o
);

    logic [NUM_SRC-1:0] prev_hw;
    logic               prev_sw;
    logic               in_flight;
    logic               hit_ok;
    logic               lower_clear;

    // Requests as seen at the previous edge, and transfer occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_hw   <= '0;
            prev_sw   <= 1'b0;
            in_flight <= 1'b0;
        end else begin
            prev_hw   <= irq_flag_i & en_q;
            prev_sw   <= sw_en_q && !swi_q;
            in_flight <= (in_flight || eng_start_o) && !(eng_done_i && eng_last_i);
        end
    end

    // Granted source was requesting and no lower index was.
    always_comb begin
        hit_ok      = 1'b0;
        lower_clear = 1'b1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eng_src_o == SEL_W'(i)) hit_ok = prev_hw[i];
            if (SEL_W'(i) < eng_src_o && prev_hw[i]) lower_clear = 1'b0;
        end
    end

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr_o)); // R5
    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr_o) |-> $past(eng_done_i && eng_last_i && !eng_dis_i && !eng_cnt_end_i)); // R5
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |=> !eng_start_o); // R4
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |-> !in_flight); // R4
    AST_HW_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start_o && eng_src_o < SEL_W'(NUM_SRC)) |-> (hit_ok && lower_clear)); // R3
    AST_SW_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start_o && eng_src_o == SEL_W'(NUM_SRC)) |-> (prev_hw == '0 && prev_sw)); // R3
    AST_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done_i && !eng_last_i) |=> (flag_clr_o == '0)); // R10

endmodule

bind xfer_act_router act_router_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_flag_i(irq_flag_i), .en_q(en_q),
    .sw_en_q(sw_en_q), .swi_q(swi_q), .eng_start_o(eng_start_o),
    .eng_src_o(eng_src_o), .eng_done_i(eng_done_i), .eng_last_i(eng_last_i),
    .eng_dis_i(eng_dis_i), .eng_cnt_end_i(eng_cnt_end_i), .flag_clr_o(flag_clr_o)
);

// File: tb/sim_xfer_act_router.sv
`timescale 1ns/1ps
// Bench for xfer_act_router: table of routing scenarios, then directed tests.
module sim_xfer_act_router;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   flags = '0;
    logic [7:0]   cpu_irq;
    logic [7:0]   clr;
    logic         swi;
    logic         we = 1'b0;
    logic         addr = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         start;
    logic [3:0]   src;
    logic [6:0]   vec;
    logic         done = 1'b0;
    logic         last = 1'b0;
    logic         dis = 1'b0;
    logic         cnt_end = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xfer_act_router u0 (
        .clk(clk), .rst_n(rst_n), .irq_flag_i(flags), .cpu_irq_o(cpu_irq),
        .flag_clr_o(clr), .cpu_swi_o(swi), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .eng_start_o(start),
        .eng_src_o(src), .eng_vec_o(vec), .eng_done_i(done), .eng_last_i(last),
        .eng_dis_i(dis), .eng_cnt_end_i(cnt_end)
    );

    // Row: {route[21:14], flags[13:6], dis[5], cnt_end[4], expected src[3:0]}
    localparam logic [21:0] ROWS [0:5] = '{
        {8'hFF, 8'h01, 1'b0, 1'b0, 4'd0},
        {8'hFF, 8'h0C, 1'b0, 1'b0, 4'd2},
        {8'hF0, 8'h8F, 1'b1, 1'b0, 4'd7},
        {8'h66, 8'h24, 1'b0, 1'b1, 4'd2},
        {8'h80, 8'hFF, 1'b0, 1'b0, 4'd7},
        {8'h18, 8'h18, 1'b1, 1'b1, 4'd3}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0; addr = 1'b0;
    endtask

    // Wait up to 8 cycles for a start, then check its source.
    task automatic wait_start(input string req, input logic [3:0] exp_src);
        for (int k = 0; k < 8 && !start; k++) tick();
        chk({req, " start seen"}, start, 1);
        chk({req, " source"}, src, exp_src);
    endtask

    // Final done with the given completion bits; returns one cycle later.
    task automatic finish_xfer(input logic d, input logic c);
        done = 1'b1; last = 1'b1; dis = d; cnt_end = c;
        tick();
        done = 1'b0; last = 1'b0; dis = 1'b0; cnt_end = 1'b0;
    endtask

    task automatic no_start(input string req, input int cycles);
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            tick();
            if (start) seen = 1'b1;
        end
        chk(req, seen, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r_en, r_fl, exp_en, exp_clr;
        logic       r_dis, r_cnt, keep;
        logic [3:0] r_src;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: idle after reset
        chk("R1 start", start, 0);
        chk("R1 clear", clr, 0);
        chk("R1 swi", swi, 0);
        chk("R1 cpu_irq", cpu_irq, 0);
        chk("R1 route reg", rdata, 0);
        addr = 1'b1; #1;
        chk("R1 sw reg", rdata, 0);
        addr = 1'b0;

        // Table walk: R3 priority, R5 keep path, R6 interrupt path
        for (int r = 0; r < 6; r++) begin
            {r_en, r_fl, r_dis, r_cnt, r_src} = ROWS[r];
            keep    = !r_dis && !r_cnt;
            exp_clr = keep ? (8'h01 << r_src) : 8'h00;
            exp_en  = keep ? r_en : (r_en & ~(8'h01 << r_src));
            reg_write(1'b0, r_en);
            flags = r_fl;
            wait_start("R3 table", r_src);
            tick();
            chk("R4 start is a pulse", start, 0);
            finish_xfer(r_dis, r_cnt);
            chk(keep ? "R5 clear pulse" : "R6 no clear", clr, exp_clr);
            chk(keep ? "R5 route kept" : "R6 route dropped", rdata, exp_en);
            chk("R6 cpu_irq", cpu_irq, r_fl & ~exp_en);
            flags = '0;
            repeat (3) tick();
        end

        // R2: flags with routing bits at 0 go to the CPU and never start
        reg_write(1'b0, 8'h00);
        flags = 8'h05;
        tick();
        chk("R2 cpu_irq", cpu_irq, 8'h05);
        no_start("R2 no start", 6);
        flags = '0;

        // R7 / R8: software request, keep path
        reg_write(1'b1, 8'hAA);
        wait_start("R7 software", 4'd8);
        chk("R7 vector", vec, 7'h2A);
        tick();
        finish_xfer(1'b0, 1'b0);
        addr = 1'b1; #1;
        chk("R8 request cleared", rdata, 8'h2A);
        chk("R8 no swi", swi, 0);
        chk("R8 no clear", clr, 0);
        addr = 1'b0;
        no_start("R8 no restart", 4);

        // R9: software request, interrupt path
        reg_write(1'b1, 8'hAA);
        wait_start("R9 software", 4'd8);
        tick();
        finish_xfer(1'b1, 1'b0);
        addr = 1'b1; #1;
        chk("R9 request kept", rdata, 8'hAA);
        chk("R9 swi raised", swi, 1);
        addr = 1'b0;
        no_start("R9 no restart", 6);
        chk("R9 swi held", swi, 1);
        reg_write(1'b1, 8'h00);
        chk("R9 swi released", swi, 0);

        // R3: hardware beats software when both are pending together
        reg_write(1'b0, 8'h28);
        flags = 8'h20;
        wait_start("R3 first", 4'd5);
        tick();
        reg_write(1'b1, 8'h81);
        flags = flags | 8'h08;
        finish_xfer(1'b0, 1'b0);
        chk("R5 clear src5", clr, 8'h20);
        flags = flags & ~8'h20;
        wait_start("R3 hw before sw", 4'd3);
        tick();
        finish_xfer(1'b0, 1'b0);
        flags = '0;
        wait_start("R3 sw last", 4'd8);
        chk("R7 vector 2", vec, 7'h01);
        tick();
        finish_xfer(1'b0, 1'b0);
        addr = 1'b1; #1;
        chk("R8 cleared after hw", rdata, 8'h01);
        addr = 1'b0;
        repeat (3) tick();

        // R10: chain link done takes no action
        reg_write(1'b0, 8'h02);
        flags = 8'h02;
        wait_start("R10 start", 4'd1);
        tick();
        done = 1'b1; last = 1'b0;
        tick();
        done = 1'b0;
        chk("R10 no clear on link", clr, 0);
        chk("R10 route unchanged", rdata, 8'h02);
        no_start("R10 still busy", 3);
        finish_xfer(1'b0, 1'b0);
        chk("R10 clear after last", clr, 8'h02);
        flags = '0;
        repeat (3) tick();

        // R11: completion clear beats a same-cycle register write
        reg_write(1'b0, 8'h10);
        flags = 8'h10;
        wait_start("R11 start", 4'd4);
        tick();
        we = 1'b1; addr = 1'b0; wdata = 8'hFF;
        finish_xfer(1'b1, 1'b0);
        we = 1'b0;
        #1;
        chk("R11 clear wins", rdata, 8'hEF);
        chk("R12 cpu_irq follows route", cpu_irq, 8'h10);
        flags = '0;
        repeat (2) tick();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule